// File: doc/BRIEF.md
# Page-Addressed Short Load/Store Unit

This unit carries out the short-form memory instructions of a small 16-bit DSP core. The caller presents a 16-bit instruction word with a one-cycle `start` strobe, together with the low byte of the page register. The unit decodes the word and then does one of three things. It loads a data-memory word into one of eight register-file sub-registers. It stores a register-file value to data memory. Or, for a reserved part of the store space, it completes without any effect.

Every access goes to one 16-bit address. The high byte of that address comes from the page register and the low byte comes from the instruction's immediate. Memory is single-port and synchronous. A load holds the unit busy for two cycles: it issues the read in the first cycle and writes the returned word into the register file in the second. A store completes in the cycle after `start`.

Top module: `short_ls_unit`

## Requirements
- R1: Every memory access uses the address `{page[7:0], insn[7:0]}`.
- R2: A word with `insn & 16'hF800 == 16'h2000` is a load. In the cycle after `start`, `mem_re` is high for one cycle. In the cycle after that, `rf_we` is high for one cycle and `rf_wdata` equals `mem_rdata`.
- R3: A load writes register index `5'h18 + insn[10:8]`. That index range holds, in order: aux0 low, aux1 low, aux0 high, aux1 high, acc0 low, acc1 low, acc0 mid, acc1 mid.
- R4: A word with `insn & 16'hFE00 == 16'h2800` reads index `5'h10 + insn[8]` (the 8-bit high part of acc0 or acc1). It stores bits [7:0] of that value sign-extended to 16 bits, and ignores bits [15:8].
- R5: A word with `insn & 16'hFC00 == 16'h2C00` stores the full 16-bit value of index `5'h1C + insn[9:8]`: acc0 low, acc1 low, acc0 mid or acc1 mid.
- R6: A word in 16'h2A00 to 16'h2BFF makes no memory access and no register write. It still raises `done` for one cycle in the cycle after `start`.
- R7: A word outside 16'h2000 to 16'h2FFF causes no memory access, no register write and no `done`.
- R8: A store raises `mem_we` and `done` together in the cycle after `start`, for one cycle per accepted store, and leaves `busy` low.
- R9: `busy` is high through both load cycles. A `start` seen while `busy` is high is ignored.
- R10: After reset, `busy`, `done`, `mem_we`, `mem_re` and `rf_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction valid strobe |
| insn | input | 16 | Instruction word |
| page | input | 8 | Low byte of the page register |
| busy | output | 1 | Load in progress |
| done | output | 1 | Instruction completed this cycle |
| rf_raddr | output | 5 | Register-file read index, derived from `insn` |
| rf_rdata | input | 16 | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 5 | Register-file write index |
| rf_wdata | output | 16 | Register-file write data |
| mem_addr | output | 16 | Data memory address |
| mem_re | output | 1 | Data memory read strobe |
| mem_we | output | 1 | Data memory write strobe |
| mem_wdata | output | 16 | Data memory write data |
| mem_rdata | input | 16 | Data memory read data, valid one cycle after `mem_re` |

## Verification
The assertions assume that the register file answers `rf_raddr` combinationally in the same cycle as `start`. They also assume that memory returns read data exactly one cycle after `mem_re`. The bench models both of these as the unit's environment: the register file is an array read through a continuous assignment, and the memory is a clocked array. The bench drives `start` and `insn` only on falling edges, so the decode inputs are stable at every rising edge. It holds `start` high during a load on purpose, to exercise the rule that a busy unit ignores new instructions.

// File: rtl/short_ls_unit.sv
module short_ls_unit #(
  parameter int DW = 16,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [15:0]   insn,
  input  logic [7:0]    page,
  output logic          busy,
  output logic          done,
  output logic [RW-1:0] rf_raddr,
  input  logic [DW-1:0] rf_rdata,
  output logic          rf_we,
  output logic [RW-1:0] rf_waddr,
  output logic [DW-1:0] rf_wdata,
  output logic [15:0]   mem_addr,
  output logic          mem_re,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  localparam int HB = 8;

  typedef enum logic [1:0] {S_IDLE, S_LREQ, S_LWB} state_t;
  state_t state;

  logic          st_done;
  logic [RW-1:0] ld_idx;

  wire in_grp = insn[15:12] == 4'h2;
  wire is_ld  = insn[15:11] == 5'b00100;
  wire is_sth = insn[15:9]  == 7'b0010100;
  wire is_rsv = insn[15:9]  == 7'b0010101;
  wire is_stl = insn[15:10] == 6'b001011;
  wire accept = start && state == S_IDLE && in_grp;
  wire [15:0] ea = {page, insn[7:0]};

  assign rf_raddr = is_sth ? RW'({4'b1000, insn[8]}) : RW'({3'b111, insn[9:8]});
  wire [DW-1:0] st_data = is_sth ? {{(DW-HB){rf_rdata[HB-1]}}, rf_rdata[HB-1:0]} : rf_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      st_done   <= 1'b0;
      ld_idx    <= '0;
    end else begin
      mem_we  <= 1'b0;
      st_done <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          mem_addr <= ea;
          if (is_ld) begin
            state  <= S_LREQ;
            ld_idx <= RW'({2'b11, insn[10:8]});
          end else begin
            st_done <= 1'b1;
            if (!is_rsv) begin
              mem_we    <= 1'b1;
              mem_wdata <= st_data;
            end
          end
        end
        S_LREQ:  state <= S_LWB;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_re   = state == S_LREQ;
  assign rf_we    = state == S_LWB;
  assign rf_waddr = ld_idx;
  assign rf_wdata = mem_rdata;
  assign busy     = state != S_IDLE;
  assign done     = st_done | rf_we;

  AST_STORE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && is_stl |=> mem_we && mem_addr == {$past(page), $past(insn[7:0])}); // R1
  AST_LOAD_WB: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> rf_we && !mem_re && busy); // R2
  AST_HI_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && is_sth |=> mem_we && mem_wdata[DW-1:HB] == {(DW-HB){mem_wdata[HB-1]}}); // R4
  AST_RSV_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && is_rsv |=> !mem_we && !mem_re && !rf_we && done); // R6
  AST_OUTSIDE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !in_grp |=> !done && !mem_we && !mem_re && !rf_we); // R7
  AST_STORE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !busy && !mem_re && done); // R8
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    start && mem_re |=> !mem_we); // R9
endmodule

// File: tb/short_ls_unit_bench.sv
`timescale 1ns/1ps
module short_ls_unit_bench;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] insn = '0;
  logic [7:0]  page = '0;
  logic busy, done, rf_we, mem_re, mem_we;
  logic [4:0]  rf_raddr, rf_waddr;
  logic [15:0] rf_rdata, rf_wdata, mem_addr, mem_wdata, mem_rdata;

  always #2.5 clk = ~clk;

  short_ls_unit u_short_ls_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .insn(insn), .page(page),
    .busy(busy), .done(done), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  logic [15:0] rf [32];
  logic [15:0] mem [1024];
  logic [15:0] ref_rf [32];
  logic [15:0] ref_mem [1024];
  int tests = 0, fails = 0;
  bit run = 0, finished = 0;

  assign rf_rdata = rf[rf_raddr];
  always @(posedge clk) begin
    if (rf_we) rf[rf_waddr] <= rf_wdata;
    if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[9:0]];
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  int m_phase = 0;
  logic m_we = 0, m_done_st = 0;
  logic [15:0] m_addr = 0, m_wdata = 0, v;
  logic [4:0] m_ldidx = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase <= 0; m_we <= 0; m_done_st <= 0;
    end else begin
      m_we <= 0; m_done_st <= 0;
      if (m_phase == 1) m_phase <= 2;
      else if (m_phase == 2) begin
        m_phase <= 0;
        ref_rf[m_ldidx] <= ref_mem[m_addr[9:0]];
      end else if (start && insn >= 16'h2000 && insn <= 16'h2FFF) begin
        m_addr <= page * 256 + insn % 256;
        if (insn < 16'h2800) begin
          m_phase <= 1;
          m_ldidx <= 5'(24 + (insn >> 8) % 8);
        end else begin
          m_done_st <= 1;
          if (insn >= 16'h2C00) v = ref_rf[28 + (insn >> 8) % 4];
          else if (insn < 16'h2A00) begin
            v = ref_rf[16 + (insn >> 8) % 2] % 256;
            if (v >= 128) v = v + 16'hFF00;
          end
          if (insn < 16'h2A00 || insn >= 16'h2C00) begin
            m_we <= 1; m_wdata <= v;
            ref_mem[10'(page * 256 + insn % 256)] <= v;
          end
        end
      end
    end
  end

  always @(negedge clk) if (rst_n && run) begin
    chk(mem_we == m_we, "R8 mem_we", mem_we, m_we);
    chk(mem_re == (m_phase == 1), "R2 mem_re", mem_re, m_phase == 1);
    chk(rf_we == (m_phase == 2), "R2 rf_we", rf_we, m_phase == 2);
    chk(done == (m_done_st || m_phase == 2), "R6 done", done, m_done_st || m_phase == 2);
    chk(busy == (m_phase != 0), "R9 busy", busy, m_phase != 0);
    if (m_we) begin
      chk(mem_addr == m_addr, "R1 store addr", mem_addr, m_addr);
      chk(mem_wdata == m_wdata, "R5 store data", mem_wdata, m_wdata);
    end
    if (m_phase == 1) chk(mem_addr == m_addr, "R1 load addr", mem_addr, m_addr);
    if (m_phase == 2) begin
      chk(rf_waddr == m_ldidx, "R3 load index", rf_waddr, m_ldidx);
      chk(rf_wdata == ref_mem[m_addr[9:0]], "R2 load data", rf_wdata, ref_mem[m_addr[9:0]]);
    end
  end

  task automatic issue(input logic [15:0] w);
    @(negedge clk); start = 1; insn = w;
    @(negedge clk); start = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin mem[i] = 16'hE000 + 16'(i); ref_mem[i] = 16'hE000 + 16'(i); end
    for (int i = 0; i < 32; i++) begin rf[i] = 16'h0100 * 16'(i) + 16'h11; ref_rf[i] = rf[i]; end
    rf[16] = 16'h1285; ref_rf[16] = 16'h1285;
    rf[17] = 16'hAB43; ref_rf[17] = 16'hAB43;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_we && !mem_re && !rf_we, "R10 reset outputs",
        {busy, done, mem_we, mem_re, rf_we}, 0);
    rst_n = 1; run = 1;
    @(negedge clk);
    for (int i = 0; i < 8; i++) issue(16'h2800 + 16'(i) * 16'h0101);
    chk(mem[0] == 16'hFF85, "R4 acc0 high sign-extended", mem[0], 16'hFF85);
    chk(mem[1] == 16'h0043, "R4 acc1 high positive", mem[1], 16'h0043);
    chk(mem[2] == 16'hE002 && mem[3] == 16'hE003, "R6 reserved left memory", {mem[2], mem[3]}, {16'hE002, 16'hE003});
    chk(mem[7] == rf[31], "R5 acc1 mid stored", mem[7], rf[31]);
    for (int i = 0; i < 8; i++) issue(16'h2000 + 16'(i) * 16'h0101);
    for (int i = 24; i < 32; i++) chk(rf[i] == ref_rf[i], "R3 readback register", rf[i], ref_rf[i]);
    chk(rf[26] == 16'hE002, "R3 aux0 high from reserved slot", rf[26], 16'hE002);
    page = 8'h34;
    issue(16'h2E5A);
    chk(mem[10'h05A] == rf[30], "R1 paged store", mem[10'h05A], rf[30]);
    issue(16'h235A);
    chk(rf[27] == rf[30], "R1 paged load", rf[27], rf[30]);
    issue(16'h2BFF);
    chk(mem[10'h0FF] == 16'hE0FF, "R6 reserved top", mem[10'h0FF], 16'hE0FF);
    page = 8'h00;
    foreach (mem[i]) begin end
    begin
      logic [15:0] outs [4] = '{16'h3000, 16'h1FFF, 16'h0000, 16'hF800};
      for (int k = 0; k < 4; k++) begin
        @(negedge clk); start = 1; insn = outs[k];
        @(negedge clk); start = 0;
        chk(!done && !mem_we && !mem_re, "R7 outside ignored", {done, mem_we, mem_re}, 0);
        @(negedge clk);
        chk(!rf_we, "R7 no register write", rf_we, 0);
      end
    end
    @(negedge clk); start = 1; insn = 16'h2006;
    @(negedge clk); insn = 16'h2C10;
    @(negedge clk);
    @(negedge clk); start = 0;
    repeat (2) @(negedge clk);
    chk(mem[16] == 16'hE010, "R9 start during load ignored", mem[16], 16'hE010);
    @(negedge clk); start = 1; insn = 16'h2C20;
    @(negedge clk); insn = 16'h2D21;
    @(negedge clk); start = 0;
    @(negedge clk);
    chk(mem[32] == rf[28] && mem[33] == rf[29], "R8 back-to-back stores", {mem[32], mem[33]}, {rf[28], rf[29]});
    for (int i = 0; i < 64; i++) chk(mem[i] == ref_mem[i], "R6 memory image", mem[i], ref_mem[i]);
    repeat (2) @(negedge clk);
    summary();
  end
endmodule